// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status and Enable Controller

This block gathers single-cycle event pulses from an Ethernet DMA engine into a word of sticky status flags that software reads and clears. To clear a flag, software writes a 1 to its bit position. Every implemented event belongs to one of two classes: normal or abnormal. Each class has its own summary flag. A summary flag is raised when an enabled event of its class is pending. It stays up until software clears it explicitly.

A companion enable word uses the same bit layout. Each event enable decides whether that event can raise its class summary. The two summary enables decide whether a summary drives the single interrupt request line. The status word also carries a read-only 3-bit receive-engine state. This field is sampled from the DMA engine. The register port is a plain 32-bit interface: a select bit, a write strobe, write data, and combinational read data.

A typical driver keeps the receive-done and normal-summary enables set. It turns the transmit-done enable on only while a transmission is in flight. When servicing, it clears each pending event first and then clears the summary.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset, the status word and the enable word both read 0, and `irq` is 0.
- R2: A pulse on `evt_pulse[i]`, where i is in 0..10 or 13..14, sets status bit i at the next clock edge. The bit stays set until it is cleared, whatever the enable word holds.
- R3: A status write (`reg_sel`=0, `reg_wr`=1) clears every status bit 0..16 whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bits 11, 12 and 20..31 always read 0. Enable bits 11, 12 and 17..31 always read 0. Writes to these bits and pulses on `evt_pulse[11]` and `evt_pulse[12]` have no visible effect.
- R6: The normal summary (status bit 16) is set one edge after any of status bits 0, 2, 6 or 14 is set together with its enable bit.
- R7: The abnormal summary (status bit 15) is set one edge after any of status bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set together with its enable bit.
- R8: A summary bit stays set after the event bits of its class are cleared. It falls only on a write of 1 to its own position, and only when no enabled event of its class is still pending.
- R9: `irq` is 1 exactly when (status bit 16 and enable bit 16) or (status bit 15 and enable bit 15) holds.
- R10: Status bits 19..17 show `rx_proc_state` as registered at the previous clock edge. They read 000 after reset and ignore writes.
- R11: An enable write (`reg_sel`=1, `reg_wr`=1) loads enable bits 0..10 and 13..16 from the write data. The enable word reads back through `reg_rdata` when `reg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = status, 1 = enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 15 | Event pulses, one per status bit position 0..14 |
| rx_proc_state | input | 3 | Receive engine state from the DMA |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters. These are a 15-bit event field with positions 11 and 12 left unimplemented, the normal class at positions 0, 2, 6 and 14, and a 3-bit receive state. This setting exercises both summary classes. It also covers the unimplemented holes inside the event field, where pulses and writes must have no effect. Because the receive state sits directly above the summaries, the bench can check that the field stays read-only and that its bits do not spill into neighbouring positions.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_ENABLE = 1'b1
   } dmairq_sel_e;

   localparam int unsigned DFLT_DATA_W = 32;
   localparam int unsigned DFLT_EVT_W  = 15;
   localparam int unsigned DFLT_RPS_W  = 3;

   // bits 0..10 and 13..14 implemented
   localparam logic [DFLT_EVT_W-1:0] DFLT_EVT_IMPL  = 15'h67FF;
   // normal class: tx done, tx buffer unavailable, rx done, early rx
   localparam logic [DFLT_EVT_W-1:0] DFLT_NORM_MASK = 15'h4045;

endpackage

// File: rtl/dmairq_w1c_bank.sv
module dmairq_w1c_bank #(
   parameter int unsigned W    = 15,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_en,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (set_i[i])
               bit_q <= 1'b1;
            else if (clr_en && clr_i[i])
               bit_q <= 1'b0;
         end
         assign q_o[i] = bit_q;
      end else begin : g_hole
         logic unused_bit;
         assign unused_bit = set_i[i] ^ clr_i[i];
         assign q_o[i]     = 1'b0;
      end
   end

   p_set_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

   p_zero_write_keeps_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> ((q_o & $past(q_o)) == $past(q_o)));

   p_holes_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (q_o & ~IMPL) == '0);

endmodule

// File: rtl/dmairq_en_reg.sv
module dmairq_en_reg #(
   parameter int unsigned W    = 17,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (wr_i)
               bit_q <= d_i[i];
         end
         assign q_o[i] = bit_q;
      end else begin : g_hole
         logic unused_bit;
         assign unused_bit = d_i[i];
         assign q_o[i]     = 1'b0;
      end
   end

   p_en_load_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (q_o == ($past(d_i) & IMPL)));

endmodule

// File: rtl/dmairq_summary.sv
module dmairq_summary #(
   parameter int unsigned W   = 15,
   parameter logic [W-1:0] GRP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] en_i,
   input  logic         clr_i,
   output logic         sum_o
);

   logic hit;
   logic sum_q;

   assign hit = |(evt_i & en_i & GRP);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sum_q <= 1'b0;
      else if (hit)
         sum_q <= 1'b1;
      else if (clr_i)
         sum_q <= 1'b0;
   end

   assign sum_o = sum_q;

   p_sum_cause_r6_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_o) |-> $past(|(evt_i & en_i & GRP)));

   p_sum_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (sum_o && !clr_i) |=> sum_o);

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
   import dmairq_pkg::*;
#(
   parameter int unsigned DATA_W = DFLT_DATA_W,
   parameter int unsigned EVT_W  = DFLT_EVT_W,
   parameter int unsigned RPS_W  = DFLT_RPS_W,
   parameter logic [EVT_W-1:0] EVT_IMPL  = DFLT_EVT_IMPL,
   parameter logic [EVT_W-1:0] NORM_MASK = DFLT_NORM_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [EVT_W-1:0]  evt_pulse,
   input  logic [RPS_W-1:0]  rx_proc_state,
   output logic              irq
);

   localparam int unsigned ABN_POS = EVT_W;
   localparam int unsigned NRM_POS = EVT_W + 1;
   localparam int unsigned SUM_W   = EVT_W + 2;
   localparam int unsigned RPS_LSB = SUM_W;
   localparam int unsigned TOP_W   = RPS_LSB + RPS_W;
   localparam logic [EVT_W-1:0] ABN_MASK = EVT_IMPL & ~NORM_MASK;
   localparam logic [SUM_W-1:0] EN_IMPL  = {2'b11, EVT_IMPL};

   if (TOP_W > DATA_W) begin : g_bad_width
      $error("dmairq_ctrl: status fields exceed DATA_W");
   end
   if ((NORM_MASK & ~EVT_IMPL) != '0) begin : g_bad_group
      $error("dmairq_ctrl: normal class names unimplemented events");
   end

   dmairq_sel_e sel;
   assign sel = dmairq_sel_e'(reg_sel);

   logic st_wr, en_wr;
   assign st_wr = reg_wr && (sel == SEL_STATUS);
   assign en_wr = reg_wr && (sel == SEL_ENABLE);

   logic [EVT_W-1:0] evt_q;
   logic [SUM_W-1:0] en_q;
   logic             nis_q, ais_q;
   logic [RPS_W-1:0] rps_q;

   dmairq_w1c_bank #(.W(EVT_W), .IMPL(EVT_IMPL)) u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_pulse),
      .clr_en(st_wr),
      .clr_i (reg_wdata[EVT_W-1:0]),
      .q_o   (evt_q)
   );

   dmairq_en_reg #(.W(SUM_W), .IMPL(EN_IMPL)) u_enable (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (en_wr),
      .d_i  (reg_wdata[SUM_W-1:0]),
      .q_o  (en_q)
   );

   dmairq_summary #(.W(EVT_W), .GRP(NORM_MASK)) u_sum_norm (
      .clk  (clk),
      .rst_n(rst_n),
      .evt_i(evt_q),
      .en_i (en_q[EVT_W-1:0]),
      .clr_i(st_wr && reg_wdata[NRM_POS]),
      .sum_o(nis_q)
   );

   dmairq_summary #(.W(EVT_W), .GRP(ABN_MASK)) u_sum_abn (
      .clk  (clk),
      .rst_n(rst_n),
      .evt_i(evt_q),
      .en_i (en_q[EVT_W-1:0]),
      .clr_i(st_wr && reg_wdata[ABN_POS]),
      .sum_o(ais_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rps_q <= '0;
      else
         rps_q <= rx_proc_state;
   end

   logic [DATA_W-1:0] status_word, enable_word;

   always_comb begin
      status_word                   = '0;
      status_word[EVT_W-1:0]        = evt_q;
      status_word[ABN_POS]          = ais_q;
      status_word[NRM_POS]          = nis_q;
      status_word[RPS_LSB +: RPS_W] = rps_q;
      enable_word                   = '0;
      enable_word[SUM_W-1:0]        = en_q;
   end

   assign reg_rdata = (sel == SEL_ENABLE) ? enable_word : status_word;
   assign irq       = (nis_q && en_q[NRM_POS]) || (ais_q && en_q[ABN_POS]);

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[DATA_W-1:SUM_W];

   p_quiet_no_irq_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!nis_q && !ais_q) |-> !irq);

   p_rps_follows_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_word[RPS_LSB +: RPS_W] == $past(rx_proc_state)));

   p_upper_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> TOP_W) == '0);

endmodule

// File: tb/dmairq_ctrl_tb.sv
module dmairq_ctrl_tb;

   localparam logic [14:0] IMPL = 15'h67FF;
   localparam logic [14:0] NORM = 15'h4045;
   localparam logic [14:0] ABN  = 15'h27BA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [14:0] evt_pulse = '0;
   logic [2:0]  rx_proc_state = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dmairq_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_sel      (reg_sel),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .evt_pulse    (evt_pulse),
      .rx_proc_state(rx_proc_state),
      .irq          (irq)
   );

   // behavioural reference model
   logic [14:0] m_evt = '0;
   logic [16:0] m_en  = '0;
   bit          m_nis = 0, m_ais = 0;
   logic [2:0]  m_rps = '0;

   always @(posedge clk) begin
      logic [31:0] clr;
      bit ns, as;
      if (!rst_n) begin
         m_evt = '0; m_en = '0; m_nis = 0; m_ais = 0; m_rps = '0;
      end else begin
         clr = (reg_wr && !reg_sel) ? reg_wdata : 32'h0;
         ns  = |(m_evt & m_en[14:0] & NORM);
         as  = |(m_evt & m_en[14:0] & ABN);
         m_nis = ns || (m_nis && !clr[16]);
         m_ais = as || (m_ais && !clr[15]);
         m_evt = ((m_evt & ~clr[14:0]) | evt_pulse) & IMPL;
         if (reg_wr && reg_sel) m_en = reg_wdata[16:0] & {2'b11, IMPL};
         m_rps = rx_proc_state;
      end
   end

   function automatic logic [31:0] m_read(input logic s);
      if (s) return {15'h0, m_en};
      return {12'h0, m_rps, m_nis, m_ais, m_evt};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #5;
         chk("model rdata", reg_rdata, m_read(reg_sel));
         chk("model irq R9", {31'h0, irq}, {31'h0, (m_nis && m_en[16]) || (m_ais && m_en[15])});
      end
   endtask

   task automatic rd(input logic s, input string req, input logic [31:0] exp);
      logic keep;
      keep    = reg_sel;
      reg_sel = s;
      #1;
      chk(req, reg_rdata, exp);
      reg_sel = keep;
      #1;
   endtask

   task automatic wr_reg(input logic s, input logic [31:0] d);
      reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
      cyc(1);
      reg_wr = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
   endtask

   task automatic pulse(input logic [14:0] v);
      evt_pulse = v;
      cyc(1);
      evt_pulse = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      cyc(1);
      // R1 reset values
      rd(1'b0, "R1 status", 32'h0);
      rd(1'b1, "R1 enable", 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2 sticky event regardless of enable
      pulse(15'h0040);
      cyc(3);
      rd(1'b0, "R2 sticky rx done", 32'h0000_0040);

      // R3 writing zero keeps, writing one clears
      wr_reg(1'b0, 32'h0);
      rd(1'b0, "R3 zero write", 32'h0000_0040);
      wr_reg(1'b0, 32'h0000_0040);
      rd(1'b0, "R3 one write", 32'h0);

      // R11 / R5 enable register
      wr_reg(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, "R11 enable readback", 32'h0001_E7FF);

      // R6 normal summary and R9 irq
      pulse(15'h0001);
      rd(1'b0, "R6 event before summary", 32'h0000_0001);
      chk("R9 irq low before summary", {31'h0, irq}, 32'h0);
      cyc(1);
      rd(1'b0, "R6 normal summary", 32'h0001_0001);
      chk("R9 irq from normal", {31'h0, irq}, 32'h1);

      // R8 summary survives clearing of its events
      wr_reg(1'b0, 32'h0000_0001);
      rd(1'b0, "R8 summary sticky", 32'h0001_0000);
      chk("R8 irq held", {31'h0, irq}, 32'h1);
      wr_reg(1'b0, 32'h0001_0000);
      rd(1'b0, "R8 summary cleared", 32'h0);
      chk("R8 irq released", {31'h0, irq}, 32'h0);

      // R7 abnormal summary, R9 summary enable gating
      pulse(15'h2000);
      cyc(1);
      rd(1'b0, "R7 abnormal summary", 32'h0000_A000);
      wr_reg(1'b1, 32'h0001_67FF);
      chk("R9 abnormal enable off", {31'h0, irq}, 32'h0);
      rd(1'b0, "R9 status kept", 32'h0000_A000);
      wr_reg(1'b1, 32'h0001_E7FF);
      wr_reg(1'b0, 32'h0000_2000);
      wr_reg(1'b0, 32'h0000_8000);
      rd(1'b0, "R7 cleared", 32'h0);

      // R4 set beats clear on same bit
      pulse(15'h0004);
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h0000_0004; evt_pulse = 15'h0004;
      cyc(1);
      reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
      chk("R4 set wins", reg_rdata & 32'h4, 32'h4);
      wr_reg(1'b0, 32'h0000_0004);
      wr_reg(1'b0, 32'h0001_0000);
      rd(1'b0, "R4 cleanup", 32'h0);

      // R5 holes ignore pulses and writes
      pulse(15'h1800);
      cyc(2);
      rd(1'b0, "R5 hole pulses", 32'h0);
      chk("R5 no irq", {31'h0, irq}, 32'h0);
      wr_reg(1'b1, 32'hFFFE_1800);
      rd(1'b1, "R5 enable holes", 32'h0);

      // R10 receive state field
      rx_proc_state = 3'b101;
      rd(1'b0, "R10 not yet sampled", 32'h0);
      cyc(1);
      rd(1'b0, "R10 state shown", 32'h000A_0000);
      wr_reg(1'b0, 32'h000E_0000);
      rd(1'b0, "R10 write ignored", 32'h000A_0000);
      rx_proc_state = 3'b000;
      cyc(2);
      rd(1'b0, "R10 back to stopped", 32'h0);

      finish_run();
   end

endmodule